// File: doc/BRIEF.md
# Glitch-Free Synchronized Clock Stop Gate

This block passes a group of clock outputs derived from one source clock and stops them on request without glitches. The stop request is active low and may arrive asynchronously; it is brought into the source-clock domain through a short flop chain before it is used. A stopped output is always parked low. A restarted output always begins with a complete high phase. Each output also has its own enable bit from a control register. Clearing that bit forces the output low through the same glitch-free path.

The block has two variants, chosen by a parameter. The processor-clock variant uses a two-flop synchronizer and keeps the group running for at least 100 high phases after every restart. The bus-clock variant uses a single sampling flop, which gives one-cycle stop and start latency, and keeps the group running for at least 10 high phases. The bus-clock variant also drives a free-running output that the request never affects. A status output reports when no gated output is pulsing.

Top module: `clk_stop_gate`

## Requirements
Edge k below is the first rising edge of `clk_src` that samples the request at its new level. A "pulse at edge t" means the gated output is high during the high phase that begins at edge t.
- R1: The request acts only after it passes the synchronizer: two flops in the processor variant and one flop in the bus variant. This is what sets the latencies in R4 and R5.
- R2: Every gated output is low throughout every low phase of `clk_src`. It stays low for as long as the group is stopped.
- R3: A gated output that is high in a high phase stays high for the whole of that high phase, even if an input changes during it.
- R4: In the processor variant, after the stop request asserts and the run window has expired, outputs still pulse at edges k and k+1 and are low from edge k+2. After the request deasserts, the first pulse is at edge k+2.
- R5: In the bus variant, after the stop request asserts and the run window has expired, outputs pulse at edge k and are low from edge k+1. After the request deasserts, the first pulse is at edge k+1.
- R6: After every restart, the group makes at least MIN_RUN consecutive pulses (100 in the processor variant, 10 in the bus variant). If the request is held asserted from the start of the window, exactly MIN_RUN pulses occur and the next edge is stopped.
- R7: A stop request that asserts and deasserts again inside the run window causes no stop.
- R8: In the bus variant, `free_clk_o` equals `clk_src` whatever the request does. In the processor variant, `free_clk_o` is held low.
- R9: When `out_en[i]` is 0, `gclk_o[i]` is forced low from the next high phase on. A change made during a high phase does not cut that phase short. Bit i controls only output i.
- R10: During each high phase of `clk_src`, `parked_o` is 1 exactly when no bit of `gclk_o` is high.
- R11: During reset and right after it, every output whose enable bit is set runs, and `parked_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock that is gated |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous active-low stop request |
| out_en | input | N_OUT | Per-output enable from a control register, 1 = run |
| gclk_o | output | N_OUT | Gated clock outputs |
| free_clk_o | output | 1 | Free-running output (bus variant), tied low otherwise |
| parked_o | output | 1 | High while no gated output is pulsing |

## Verification
The assertion that ties each run/stop change to the synchronized request assumes two things: the request holds each new level for at least the synchronizer depth plus two edges, and it changes only away from a rising edge. The enables are assumed to change only during a high phase, the way a register in the same domain would. The stimulus drives every input one nanosecond after a rising edge. Outside the deliberate short pulse of the R7 case, it holds each request level for several cycles, so all inputs stay inside these assumptions.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;
  typedef enum logic {
    FLAV_CPU = 1'b0,
    FLAV_BUS = 1'b1
  } flavour_e;

  function automatic int sync_depth(flavour_e f);
    return (f == FLAV_BUS) ? 1 : 2;
  endfunction

  function automatic int run_window(flavour_e f, int cpu_min, int bus_min);
    return (f == FLAV_BUS) ? bus_min : cpu_min;
  endfunction
endpackage

// File: rtl/clk_stop_sync.sv
module clk_stop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic req_n_i,
  output logic stop_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) chain_q <= 1'b1;
        else        chain_q <= req_n_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], req_n_i};
      end
    end
  endgenerate

  assign stop_o = ~chain_q[STAGES-1];
endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl #(
  parameter int MIN_RUN = 100
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic stop_i,
  output logic run_d_o,
  output logic run_q_o
);
  localparam int CW = $clog2(MIN_RUN + 1);

  logic [CW-1:0] pulses_q;
  logic          run_q;
  logic          window_done;
  logic          run_d;

  assign window_done = (pulses_q == CW'(MIN_RUN));
  // keep running while not requested, or while the minimum run window is open
  assign run_d = !stop_i || (run_q && !window_done);

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b1;
      pulses_q <= '0;
    end else begin
      run_q <= run_d;
      if (!run_d)            pulses_q <= '0;
      else if (!window_done) pulses_q <= pulses_q + 1'b1;
    end
  end

  assign run_d_o = run_d;
  assign run_q_o = run_q;
endmodule

// File: rtl/clk_stop_gate_cell.sv
module clk_stop_gate_cell (
  input  logic clk_i,
  input  logic en_i,
  output logic held_o,
  output logic gclk_o
);
  logic en_lat;

  // transparent only while the clock is low, so the AND never sees a change mid-high
  always_latch begin
    if (!clk_i) en_lat <= en_i;
  end

  assign held_o = en_lat;
  assign gclk_o = clk_i & en_lat;
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate
  import clk_stop_pkg::*;
#(
  parameter flavour_e FLAVOUR     = FLAV_CPU,
  parameter int       N_OUT       = 3,
  parameter int       MIN_RUN_CPU = 100,
  parameter int       MIN_RUN_BUS = 10
) (
  input  logic             clk_src,
  input  logic             rst_n,
  input  logic             stop_req_n,
  input  logic [N_OUT-1:0] out_en,
  output logic [N_OUT-1:0] gclk_o,
  output logic             free_clk_o,
  output logic             parked_o
);
  localparam int SYNC_STAGES = sync_depth(FLAVOUR);
  localparam int MIN_RUN     = run_window(FLAVOUR, MIN_RUN_CPU, MIN_RUN_BUS);

  logic             stop_sync;
  logic             run_d;
  logic             run_q;
  logic [N_OUT-1:0] held;

  clk_stop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_src),
    .rst_n   (rst_n),
    .req_n_i (stop_req_n),
    .stop_o  (stop_sync)
  );

  clk_stop_ctrl #(.MIN_RUN(MIN_RUN)) u_ctrl (
    .clk_i   (clk_src),
    .rst_n   (rst_n),
    .stop_i  (stop_sync),
    .run_d_o (run_d),
    .run_q_o (run_q)
  );

  generate
    for (genvar i = 0; i < N_OUT; i++) begin : g_out
      clk_stop_gate_cell u_cell (
        .clk_i  (clk_src),
        .en_i   (run_d & out_en[i]),
        .held_o (held[i]),
        .gclk_o (gclk_o[i])
      );
    end
    if (FLAVOUR == FLAV_BUS) begin : g_free
      assign free_clk_o = clk_src;
    end else begin : g_nofree
      assign free_clk_o = 1'b0;
    end
  endgenerate

  assign parked_o = ~|held;
endmodule

// File: rtl/clk_stop_gate_chk.sv
module clk_stop_gate_chk
  import clk_stop_pkg::*;
#(
  parameter flavour_e FLAVOUR     = FLAV_CPU,
  parameter int       N_OUT       = 3,
  parameter int       MIN_RUN     = 100,
  parameter int       SYNC_STAGES = 2
) (
  input logic             clk_src,
  input logic             rst_n,
  input logic             stop_req_n,
  input logic [N_OUT-1:0] gclk_o,
  input logic             free_clk_o,
  input logic             parked_o,
  input logic             run_q
);
  localparam int LW = $clog2(MIN_RUN + 1);
  logic [LW-1:0] run_len;

  // consecutive gated edges seen so far, saturating
  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n)                      run_len <= '0;
    else if (!run_q)                 run_len <= '0;
    else if (run_len != LW'(MIN_RUN)) run_len <= run_len + 1'b1;
  end

  // R2: sampled just before each rising edge, i.e. in the low phase
  a_r2_low_phase: assert property (@(posedge clk_src) disable iff (!rst_n)
    gclk_o == '0);

  // R6: a run interval only ends after the minimum window
  a_r6_min_run: assert property (@(posedge clk_src) disable iff (!rst_n)
    $fell(run_q) |-> run_len == LW'(MIN_RUN));

  // R1: run/stop changes follow the synchronized request
  a_r1_sync_stop: assert property (@(posedge clk_src) disable iff (!rst_n)
    $fell(run_q) |-> !$past(stop_req_n, SYNC_STAGES + 1));
  a_r1_sync_go: assert property (@(posedge clk_src) disable iff (!rst_n)
    $rose(run_q) |-> $past(stop_req_n, SYNC_STAGES + 1));

  // R10: sampled at the falling edge, i.e. in the high phase
  a_r10_parked: assert property (@(negedge clk_src) disable iff (!rst_n)
    parked_o == (gclk_o == '0));

  generate
    if (FLAVOUR == FLAV_BUS) begin : g_bus
      a_r8_free_high: assert property (@(negedge clk_src) disable iff (!rst_n)
        free_clk_o == 1'b1);
    end else begin : g_cpu
      a_r8_free_tied: assert property (@(negedge clk_src) disable iff (!rst_n)
        free_clk_o == 1'b0);
    end
  endgenerate
endmodule

bind clk_stop_gate clk_stop_gate_chk #(
  .FLAVOUR(FLAVOUR), .N_OUT(N_OUT), .MIN_RUN(MIN_RUN), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk_src    (clk_src),
  .rst_n      (rst_n),
  .stop_req_n (stop_req_n),
  .gclk_o     (gclk_o),
  .free_clk_o (free_clk_o),
  .parked_o   (parked_o),
  .run_q      (run_q)
);

// File: tb/clk_stop_gate_bench.sv
`timescale 1ns/100ps
module clk_stop_gate_bench;
  import clk_stop_pkg::*;
  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_p = 1'b1, req_b = 1'b1;
  logic [N-1:0] en_p = '1, en_b = '1;
  logic [N-1:0] g_p, g_b, hp, hb;
  logic         fr_p, fr_b, pk_p, pk_b;
  int           n_chk = 0, n_bad = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  clk_stop_gate #(.FLAVOUR(FLAV_CPU), .N_OUT(N)) u_clk_stop_gate (
    .clk_src(clk), .rst_n(rst_n), .stop_req_n(req_p), .out_en(en_p),
    .gclk_o(g_p), .free_clk_o(fr_p), .parked_o(pk_p));

  clk_stop_gate #(.FLAVOUR(FLAV_BUS), .N_OUT(N)) u_clk_stop_gate_bus (
    .clk_src(clk), .rst_n(rst_n), .stop_req_n(req_b), .out_en(en_b),
    .gclk_o(g_b), .free_clk_o(fr_b), .parked_o(pk_b));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic stepn(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  // R3 / R2 / R8 phase monitor
  always @(posedge clk) begin
    if (rst_n) begin
      #0.5;
      hp = g_p;
      hb = g_b;
      check(fr_b == 1'b1, "R8 bus free output high in high phase", fr_b, 1);
      #1.5;
      check(g_p == hp, "R3 cpu high phase held whole", g_p, hp);
      check(g_b == hb, "R3 bus high phase held whole", g_b, hb);
      #1.5;
      check(g_p == '0, "R2 cpu low in low phase", g_p, 0);
      check(g_b == '0, "R2 bus low in low phase", g_b, 0);
      check(fr_p == 1'b0, "R8 cpu free output tied low", fr_p, 0);
    end
  end

  initial begin
    stepn(3);
    check(g_p == 3'b111, "R11 cpu runs in reset", g_p, 7);
    check(g_b == 3'b111, "R11 bus runs in reset", g_b, 7);
    check(pk_b == 1'b0, "R11 bus not parked in reset", pk_b, 0);
    rst_n = 1'b1;
    stepn(5);
    check(g_p == 3'b111, "R11 cpu runs after reset", g_p, 7);
    check(g_b == 3'b111, "R11 bus runs after reset", g_b, 7);
    check(pk_p == 1'b0, "R11 cpu not parked after reset", pk_p, 0);

    // bus stop latency
    stepn(20);
    req_b = 1'b0;
    stepn(1); check(g_b == 3'b111, "R5 bus pulses at sampling edge", g_b, 7);
    stepn(1); check(g_b == 3'b000, "R1 R5 bus stopped one edge later", g_b, 0);
    check(pk_b == 1'b1, "R10 bus parked when stopped", pk_b, 1);
    for (int i = 0; i < 15; i++) begin
      stepn(1); check(g_b == 3'b000, "R2 bus held low while stopped", g_b, 0);
    end
    en_b = 3'b010;
    stepn(2); check(g_b == 3'b000, "R9 enable does not override stop", g_b, 0);
    en_b = '1;

    // bus resume, then deferred stop
    req_b = 1'b1;
    stepn(1); check(g_b == 3'b000, "R5 bus still low at sampling edge", g_b, 0);
    stepn(1); check(g_b == 3'b111, "R5 bus resumes one edge later", g_b, 7);
    req_b = 1'b0;
    for (int i = 0; i < 9; i++) begin
      stepn(1); check(g_b == 3'b111, "R6 bus stop deferred in window", g_b, 7);
    end
    stepn(1); check(g_b == 3'b000, "R6 bus stops after exactly 10", g_b, 0);

    // short request inside window
    stepn(3);
    req_b = 1'b1;
    stepn(2); check(g_b == 3'b111, "R5 bus resumed", g_b, 7);
    stepn(1);
    req_b = 1'b0;
    stepn(2);
    req_b = 1'b1;
    for (int i = 0; i < 30; i++) begin
      stepn(1); check(g_b == 3'b111, "R7 short request ignored", g_b, 7);
    end

    // per-output enables
    en_b = 3'b101;
    stepn(1); check(g_b == 3'b101, "R9 bus enable mask", g_b, 5);
    check(pk_b == 1'b0, "R10 bus not parked with one enable", pk_b, 0);
    en_b = 3'b000;
    stepn(1); check(g_b == 3'b000, "R9 bus all disabled", g_b, 0);
    check(pk_b == 1'b1, "R10 bus parked with enables clear", pk_b, 1);
    for (int v = 0; v < 8; v++) begin
      en_b = v[N-1:0];
      stepn(1);
      check(g_b == v[N-1:0], "R9 bus enable sweep", g_b, v);
      check(pk_b == (v == 0), "R10 bus parked sweep", pk_b, int'(v == 0));
    end
    en_b = '1;
    stepn(1);

    // free-running output while stopped
    req_b = 1'b0;
    stepn(3);
    check(g_b == 3'b000, "R8 bus group stopped", g_b, 0);
    check(fr_b == 1'b1, "R8 free output runs while stopped", fr_b, 1);

    // cpu stop latency
    stepn(5);
    req_p = 1'b0;
    stepn(1); check(g_p == 3'b111, "R4 cpu pulses at sampling edge", g_p, 7);
    stepn(1); check(g_p == 3'b111, "R1 R4 cpu second pulse via two-flop sync", g_p, 7);
    stepn(1); check(g_p == 3'b000, "R4 cpu stopped", g_p, 0);
    check(pk_p == 1'b1, "R10 cpu parked", pk_p, 1);
    stepn(10); check(g_p == 3'b000, "R2 cpu held low", g_p, 0);

    // cpu resume and deferred stop
    req_p = 1'b1;
    stepn(1); check(g_p == 3'b000, "R4 cpu low at sampling edge", g_p, 0);
    stepn(1); check(g_p == 3'b000, "R1 R4 cpu low one edge later", g_p, 0);
    stepn(1); check(g_p == 3'b111, "R4 cpu resumes two edges later", g_p, 7);
    req_p = 1'b0;
    for (int i = 0; i < 99; i++) begin
      stepn(1); check(g_p == 3'b111, "R6 cpu stop deferred in window", g_p, 7);
    end
    stepn(1); check(g_p == 3'b000, "R6 cpu stops after exactly 100", g_p, 0);

    // partial enable on resume
    en_p = 3'b100;
    req_p = 1'b1;
    stepn(3); check(g_p == 3'b100, "R9 cpu partial enable on resume", g_p, 4);
    en_p = '1;
    stepn(1); check(g_p == 3'b111, "R9 cpu full enable restored", g_p, 7);

    stepn(2);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule